// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block sits between an on-chip master and an external asynchronous static RAM of 65,536 sixteen-bit words. The master hands over one command at a time through a valid/ready handshake. Each command carries an address, a write flag, one enable bit per byte lane and the write data. The controller turns the command into a timed sequence of active-low memory strobes. When the access is over, it answers with a single-cycle response pulse, which carries the read data for a read.

The data bus to the memory is split into three signals: an outgoing value, an incoming value and a drive enable. For a write, the controller drives the bus for one setup cycle. It then holds the write strobe low for `WRITE_WAIT` clocks while keeping the output-enable strobe high, so the memory never drives back. For a read, it holds chip enable and output enable low for `READ_WAIT` clocks and never drives the bus. Byte selects come from the lane enables. A lane that is not enabled is neither written nor returned: its read bits come back as zero.

Every memory-side output is a register. Address, data and selects change only when an access starts, so the memory's zero address setup and zero hold margins are met at both ends of the write strobe.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip enable, write enable, output enable and both byte selects are high, bus drive is low, `cmd_ready` is high and `rsp_valid` is low.
- R2: A write shows exactly one setup cycle (chip enable low, write enable high, bus driven), followed by exactly `WRITE_WAIT` cycles with write enable low. Chip enable stays low and output enable stays high throughout.
- R3: The controller drives the bus only during a write's setup and strobe cycles. The bus is never driven while output enable is low, and write enable is never low without bus drive.
- R4: `mem_bsel_n[0]` gates data bits 7..0 and `mem_bsel_n[1]` gates bits 15..8. Each is low exactly when chip enable is low and the matching `cmd_be` bit was 1. A lane whose select stays high keeps its stored value after a write.
- R5: A read holds chip enable and output enable low and write enable high for exactly `READ_WAIT` cycles.
- R6: Read data is captured at the end of the last read strobe cycle and returned with `rsp_valid` one cycle later. Bits of lanes whose enable was 0 are returned as zero.
- R7: The write response pulse appears in the first cycle after write enable rises, with bus drive already released. It comes `WRITE_WAIT`+2 cycles after acceptance; a read response comes `READ_WAIT`+1 cycles after acceptance.
- R8: Output enable never falls in a cycle that directly follows a cycle with bus drive active.
- R9: `cmd_ready` is high only when no access is in progress and chip enable is high. A command is taken when `cmd_valid` and `cmd_ready` are both high. `rsp_valid` never lasts more than one cycle.
- R10: From the write setup cycle to the end of the write strobe, the address, outgoing data and byte selects do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Master presents a command |
| cmd_ready | output | 1 | Controller idle; a command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Word address |
| cmd_be | input | 2 | Lane enables; bit 0 = bits 7..0, bit 1 = bits 15..8 |
| cmd_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data; disabled lanes are zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bsel_n | output | 2 | Byte selects, active low; bit 0 lower lane, bit 1 upper lane |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data returned by the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The assertions assume that `mem_dq_in` is driven only by a memory that obeys the control truth table. They also assume that command fields matter only in the cycle a command is accepted. The stimulus follows this: the bench memory model drives only the selected lanes while a read is decoded, and fills the unselected lanes with a fixed filler byte. The master presents each command for exactly the accepting cycle and waits for the response before issuing the next one. Random commands are drawn from a small address window so that reads often land on words written earlier with a different lane mask.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSETUP  = 3'd1,
    ST_WSTROBE = 3'd2,
    ST_RSTROBE = 3'd3,
    ST_DONE    = 3'd4
  } ctl_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0]        lane_en,
  input  logic                    active,
  input  logic [LANES*LANE_W-1:0] rd_raw,
  output logic [LANES-1:0]        sel_n,
  output logic [LANES*LANE_W-1:0] rd_masked
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_n[g] = ~(lane_en[g] & active);
    assign rd_masked[g*LANE_W +: LANE_W] =
      lane_en[g] ? rd_raw[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int LANE_W     = 8,
  parameter int READ_WAIT  = 4,
  parameter int WRITE_WAIT = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic                        cmd_write,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [DATA_W/LANE_W-1:0]    cmd_be,
  input  logic [DATA_W-1:0]           cmd_wdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic                        mem_ce_n,
  output logic                        mem_we_n,
  output logic                        mem_oe_n,
  output logic [DATA_W/LANE_W-1:0]    mem_bsel_n,
  output logic [DATA_W-1:0]           mem_dq_out,
  input  logic [DATA_W-1:0]           mem_dq_in,
  output logic                        mem_dq_oe
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int CNT_W = $clog2(max2(READ_WAIT, WRITE_WAIT) + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(READ_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WRITE_WAIT - 1);

  ctl_state_t       st, nxt;
  logic [LANES-1:0] be_q, be_src, sel_n_nxt;
  logic [DATA_W-1:0] rd_masked;
  logic             accept, active_nxt, t_load, t_last;
  logic [CNT_W-1:0] t_val;

  assign accept = (st == ST_IDLE) && cmd_valid;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:    if (cmd_valid) nxt = cmd_write ? ST_WSETUP : ST_RSTROBE;
      ST_WSETUP:  nxt = ST_WSTROBE;
      ST_WSTROBE: if (t_last) nxt = ST_DONE;
      ST_RSTROBE: if (t_last) nxt = ST_DONE;
      ST_DONE:    nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  // The timer is loaded in the cycle before a strobe window opens.
  assign t_load = accept || (st == ST_WSETUP);
  assign t_val  = (st == ST_WSETUP) ? WR_LOAD : RD_LOAD;

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  assign active_nxt = (nxt == ST_WSETUP) || (nxt == ST_WSTROBE) ||
                      (nxt == ST_RSTROBE);
  assign be_src     = accept ? cmd_be : be_q;

  sram_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .lane_en   (be_src),
    .active    (active_nxt),
    .rd_raw    (mem_dq_in),
    .sel_n     (sel_n_nxt),
    .rd_masked (rd_masked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      be_q       <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_bsel_n <= '1;
      mem_dq_oe  <= 1'b0;
      cmd_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      st <= nxt;
      if (accept) begin
        be_q     <= cmd_be;
        mem_addr <= cmd_addr;
        if (cmd_write) mem_dq_out <= cmd_wdata;
      end
      mem_ce_n   <= ~active_nxt;
      mem_we_n   <= ~(nxt == ST_WSTROBE);
      mem_oe_n   <= ~(nxt == ST_RSTROBE);
      mem_dq_oe  <= (nxt == ST_WSETUP) || (nxt == ST_WSTROBE);
      mem_bsel_n <= sel_n_nxt;
      cmd_ready  <= (nxt == ST_IDLE);
      rsp_valid  <= (nxt == ST_DONE);
      if ((st == ST_RSTROBE) && t_last) rsp_rdata <= rd_masked;
    end
  end
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_bsel_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  // R3
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));

  // R3
  strobe_driven_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);

  // R2
  strobe_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  // R10
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |->
      ($stable(mem_addr) && $stable(mem_dq_out) && $stable(mem_bsel_n)));

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (mem_ce_n && mem_we_n && mem_oe_n));

  // R4
  lane_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_bsel_n != '1) |-> !mem_ce_n);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(DATA_W / LANE_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cmd_ready  (cmd_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_bsel_n (mem_bsel_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
  localparam int RW = 4;
  localparam int WW = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0, cmd_wdata = '0;
  logic [1:0]  cmd_be = '0;
  logic        cmd_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_bsel_n;

  int checks = 0;
  int errors = 0;
  int cont_err = 0;
  int turn_err = 0;
  int undriven_err = 0;
  logic prev_dq = 1'b0;

  logic [15:0] model  [0:255];
  logic [15:0] shadow [0:255];

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(.READ_WAIT(RW), .WRITE_WAIT(WW)) uut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_be(cmd_be), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_bsel_n(mem_bsel_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // Behavioural memory: reads drive selected lanes, others carry filler.
  always_comb begin
    for (int i = 0; i < 2; i++) begin
      if (!mem_ce_n && mem_we_n && !mem_oe_n && !mem_bsel_n[i])
        mem_dq_in[i*8 +: 8] = model[mem_addr[7:0]][i*8 +: 8];
      else
        mem_dq_in[i*8 +: 8] = 8'hA5;
    end
  end

  always @(posedge clk) begin
    if (!rst && !mem_ce_n && !mem_we_n) begin
      if (!mem_dq_oe) undriven_err++;
      for (int i = 0; i < 2; i++)
        if (!mem_bsel_n[i]) model[mem_addr[7:0]][i*8 +: 8] <= mem_dq_out[i*8 +: 8];
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_dq_oe && !mem_ce_n && mem_we_n && !mem_oe_n) cont_err++;
      if (!mem_oe_n && prev_dq) turn_err++;
      prev_dq = mem_dq_oe;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] addr_of(input int k);
    if (k == 0) return 16'h0000;
    if (k == 1) return 16'hFFFF;
    return 16'h1230 + 16'(k - 2);
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic run_cmd(input bit wr, input logic [15:0] a,
                         input logic [1:0] be, input logic [15:0] d);
    int n, strobes, setups, busy_rdy, hold_bad, lane_bad;
    logic [15:0] m;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_be = be; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_wdata = ~d; cmd_addr = ~a; cmd_be = ~be;
    n = 1; strobes = 0; setups = 0; busy_rdy = 0; hold_bad = 0; lane_bad = 0;
    while (!rsp_valid && n < 60) begin
      if (wr && !mem_we_n) strobes++;
      if (!wr && !mem_oe_n && !mem_ce_n && mem_we_n) strobes++;
      if (wr && mem_dq_oe && mem_we_n && !mem_ce_n) setups++;
      if (wr && !mem_we_n && (mem_ce_n || !mem_oe_n)) hold_bad++;
      if (cmd_ready) busy_rdy++;
      if (!mem_ce_n && mem_addr !== a) hold_bad++;
      if (wr && mem_dq_oe && mem_dq_out !== d) hold_bad++;
      if (!mem_ce_n && mem_bsel_n !== ~be) lane_bad++;
      @(negedge clk);
      n++;
    end
    m = lane_mask(be);
    chk(busy_rdy == 0, "R9 ready while busy", busy_rdy, 0);
    chk(lane_bad == 0, "R4 byte selects", lane_bad, 0);
    if (wr) begin
      chk(strobes == WW, "R2 strobe cycles", strobes, WW);
      chk(setups == 1, "R2 setup cycles", setups, 1);
      chk(hold_bad == 0, "R10 addr/data stable", hold_bad, 0);
      chk(n == WW + 2 && mem_we_n && !mem_dq_oe, "R7 write response", n, WW + 2);
      shadow[a[7:0]] = (shadow[a[7:0]] & ~m) | (d & m);
    end else begin
      chk(strobes == RW, "R5 read strobe cycles", strobes, RW);
      chk(hold_bad == 0, "R5 read framing", hold_bad, 0);
      chk(n == RW + 1, "R7 read latency", n, RW + 1);
      chk(rsp_rdata === (shadow[a[7:0]] & m), "R6 read data", rsp_rdata,
          shadow[a[7:0]] & m);
    end
    @(negedge clk);
    chk(!rsp_valid, "R9 single-cycle response", rsp_valid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      model[i] = 16'hDEAD;
      shadow[i] = 16'hDEAD;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_bsel_n == 2'b11 && !mem_dq_oe,
        "R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_bsel_n, mem_dq_oe}, 6'b111110);
    chk(cmd_ready && !rsp_valid, "R1 handshake idle", {cmd_ready, rsp_valid}, 2'b10);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < 10; k++) run_cmd(1'b1, addr_of(k), 2'b11, 16'h1111 * 16'(k + 1));
    // Corner: address extremes and single lanes (R4, R6)
    run_cmd(1'b1, 16'hFFFF, 2'b01, 16'hBEEF);
    run_cmd(1'b0, 16'hFFFF, 2'b11, 16'h0);
    run_cmd(1'b1, 16'h0000, 2'b10, 16'hC0DE);
    run_cmd(1'b0, 16'h0000, 2'b11, 16'h0);
    // R4: no lane enabled leaves the word unchanged
    run_cmd(1'b1, 16'h1231, 2'b00, 16'h5A5A);
    run_cmd(1'b0, 16'h1231, 2'b11, 16'h0);
    // R6: disabled lanes read as zero
    run_cmd(1'b0, 16'h1232, 2'b01, 16'h0);
    run_cmd(1'b0, 16'h1232, 2'b10, 16'h0);
    run_cmd(1'b0, 16'h1232, 2'b00, 16'h0);
    for (int i = 0; i < 120; i++)
      run_cmd(1'($urandom % 2), addr_of(int'($urandom % 10)), 2'($urandom % 4),
              16'($urandom));
    for (int k = 0; k < 10; k++) run_cmd(1'b0, addr_of(k), 2'b11, 16'h0);

    chk(cont_err == 0, "R3 bus contention", cont_err, 0);
    chk(undriven_err == 0, "R3 strobe without drive", undriven_err, 0);
    chk(turn_err == 0, "R8 turnaround gap", turn_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule